// File: doc/BRIEF.md
# OSD Configuration Register Slave on a Two-Wire Serial Bus

This block is a target on a two-wire serial bus (I2C) and answers only to a fixed 7-bit address. Through it, a host can write the settings that drive an on-screen text overlay: a start position, a control byte, seven character codes and a character count. The host can also read the per-channel status of four video receivers: no signal, not locked and active. All bus lines are oversampled in the system clock domain. Each line passes through a two-flop synchronizer and a glitch filter before START and STOP are detected.

In a write, the first data byte after the address sets an internal register pointer. Each later byte goes to the pointed register, and the pointer then advances. A read starts at the current pointer, which is usually set by a write that ends in a repeated START. The pointer advances after every byte sent. The host ends a read by answering the last byte with NACK. The status inputs are sampled at the moment a read byte is loaded, so a change on those inputs cannot alter a byte that is already being shifted out.

Top module: `osd_cfg_i2c_slave`

## Requirements
- R1: After reset, every configuration output is zero (position, control, all characters, count) and `sda_oe` is low.
- R2: The slave ACKs only a first byte whose upper seven bits equal 0x30 (R/W in bit 0, so 0x60 writes and 0x61 reads). Any other address gets NACK: SDA is not driven and no register changes.
- R3: In a write, the first data byte loads the pointer. Each following byte is stored at the pointer, and the pointer then increments. Every data byte is ACKed.
- R4: Writable map. Address 0x00+i is character i (i = 0..6), placed on `osd_char[8i+7:8i]`. Address 0x07 is the character count, 0x31 is the start position and 0x32 is the control byte.
- R5: The control register keeps only bits [5:0], with size in [5:4] and colour in [3:0]. Written bits [7:6] are dropped and read back as 0.
- R6: Address 0x11 reads no-signal, 0x12 reads not-locked and 0x13 reads active. Bit n holds channel n in bits [3:0], and bits [7:4] read 0.
- R7: Writes to the status addresses or to unmapped addresses are ACKed but change no output.
- R8: A read from an unmapped address returns 0x00.
- R9: In a read, the pointer advances after each byte. A host ACK continues with the next register. A host NACK ends the transfer and releases SDA.
- R10: A status byte is sampled when it is loaded for shifting. A status input that changes during the byte does not alter that byte, and the next read shows the new value.
- R11: `sda_oe` changes only while SCL is low. A repeated START restarts address decoding, and STOP returns the slave to idle.
- R12: A pulse on SCL or SDA shorter than the filter length (3 cycles by default) is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen on the pad |
| sda_i | input | 1 | Bus data line as seen on the pad |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| ch_nosig | input | 4 | Per-channel no-signal flags, channel n on bit n |
| ch_unlock | input | 4 | Per-channel not-locked flags |
| ch_active | input | 4 | Per-channel valid-video flags |
| osd_pos | output | 8 | Text start position register |
| osd_ctrl | output | 6 | Size [5:4] and colour [3:0] |
| osd_char | output | 56 | Seven 8-bit character codes, character i at [8i+7:8i] |
| osd_char_cnt | output | 8 | Number of characters to show |

## Verification
The assertions assume the host keeps each SCL high and low phase longer than the synchronizer, filter and edge-detect latency, about six clocks. They also assume SDA from the host changes only while SCL is low, except at START and STOP. Without this, "SDA changes only with SCL low" would not hold at the pads. The bench keeps every bus phase at ten or twenty clocks. It changes SDA at least ten clocks after SCL falls. Its deliberate glitches last two clocks, less than the filter length, so the bench never violates these assumptions.

// File: rtl/i2c_cfg_pkg.sv
// Package: shared bus states and the register address map of the
// configuration slave. Addresses are fixed because software depends on them.
package i2c_cfg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR,
        ST_WR_ACK,
        ST_RD,
        ST_RD_ACK
    } bus_st_t;

    localparam int          NUM_CHAR      = 7;
    localparam int          NUM_CHAN      = 4;
    localparam logic [7:0]  REG_CHAR0     = 8'h00;
    localparam logic [7:0]  REG_CHAR_CNT  = 8'h07;
    localparam logic [7:0]  REG_POS       = 8'h31;
    localparam logic [7:0]  REG_CTRL      = 8'h32;
    localparam logic [7:0]  REG_NOSIG     = 8'h11;
    localparam logic [7:0]  REG_UNLOCK    = 8'h12;
    localparam logic [7:0]  REG_ACTIVE    = 8'h13;

endpackage

// File: rtl/i2c_glitch_filter.sv
// Module: two-flop synchronizer followed by a persistence filter.
// The output follows the input only after the synchronized input has held a
// new level for FILT_LEN consecutive clocks. Assumes the idle bus level is 1.
module i2c_glitch_filter #(
    parameter int FILT_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o
);
    localparam int CW = $clog2(FILT_LEN + 1);

    logic [1:0]    sync_q;
    logic [CW-1:0] cnt_q;

    // Bring the asynchronous pad level into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= 2'b11;
        else        sync_q <= {sync_q[0], line_i};
    end

    // Accept a new level only after it persists for FILT_LEN clocks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_o <= 1'b1;
            cnt_q  <= '0;
        end else if (sync_q[1] == line_o) begin
            cnt_q  <= '0;
        end else if (cnt_q == CW'(FILT_LEN - 1)) begin
            line_o <= sync_q[1];
            cnt_q  <= '0;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/i2c_bus_engine.sv
// Module: bit and byte engine of the slave. It works on filtered SCL/SDA,
// detects START/STOP, matches the device address, ACKs, shifts bytes and
// keeps the auto-incrementing register pointer. It assumes no clock
// stretching and 7-bit addressing only. The read byte is loaded from rd_data
// on the SCL fall that begins it.
module i2c_bus_engine
    import i2c_cfg_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h30
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_f,
    input  logic       sda_f,
    input  logic [7:0] rd_data,
    output logic [7:0] ptr,
    output logic       wr_en,
    output logic [7:0] wr_addr,
    output logic [7:0] wr_data,
    output logic       sda_oe
);
    bus_st_t    st_q;
    logic       scl_q, sda_q;
    logic [7:0] shreg;
    logic [3:0] bitcnt;
    logic       rnw_q;
    logic       first_q;
    logic       mack_q;

    logic scl_rise, scl_fall, start_ev, stop_ev, byte_done;

    // Remember the previous filtered levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
        end
    end

    // Decode bus events from the filtered lines.
    always_comb begin
        scl_rise  = scl_f & ~scl_q;
        scl_fall  = ~scl_f & scl_q;
        start_ev  = scl_f & scl_q & sda_q & ~sda_f;
        stop_ev   = scl_f & scl_q & ~sda_q & sda_f;
        byte_done = scl_fall && (bitcnt == 4'd8);
    end

    // Protocol state machine, shifting and pointer handling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            shreg   <= '0;
            bitcnt  <= '0;
            rnw_q   <= 1'b0;
            first_q <= 1'b0;
            mack_q  <= 1'b0;
            ptr     <= '0;
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
            sda_oe  <= 1'b0;
        end else begin
            wr_en <= 1'b0;
            if (start_ev) begin
                st_q    <= ST_ADDR;
                bitcnt  <= '0;
                first_q <= 1'b1;
                sda_oe  <= 1'b0;
            end else if (stop_ev) begin
                st_q   <= ST_IDLE;
                sda_oe <= 1'b0;
            end else begin
                unique case (st_q)
                    ST_IDLE: ;
                    ST_ADDR: begin
                        if (scl_rise) begin
                            shreg  <= {shreg[6:0], sda_f};
                            bitcnt <= bitcnt + 1'b1;
                        end
                        if (byte_done) begin
                            if (shreg[7:1] == DEV_ADDR) begin
                                sda_oe <= 1'b1;
                                rnw_q  <= shreg[0];
                                st_q   <= ST_ADDR_ACK;
                            end else begin
                                st_q   <= ST_IDLE;
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (scl_fall) begin
                            bitcnt <= '0;
                            if (rnw_q) begin
                                shreg  <= rd_data;
                                sda_oe <= ~rd_data[7];
                                st_q   <= ST_RD;
                            end else begin
                                sda_oe <= 1'b0;
                                st_q   <= ST_WR;
                            end
                        end
                    end
                    ST_WR: begin
                        if (scl_rise) begin
                            shreg  <= {shreg[6:0], sda_f};
                            bitcnt <= bitcnt + 1'b1;
                        end
                        if (byte_done) begin
                            sda_oe <= 1'b1;
                            st_q   <= ST_WR_ACK;
                            if (first_q) begin
                                ptr     <= shreg;
                                first_q <= 1'b0;
                            end else begin
                                wr_en   <= 1'b1;
                                wr_addr <= ptr;
                                wr_data <= shreg;
                                ptr     <= ptr + 1'b1;
                            end
                        end
                    end
                    ST_WR_ACK: begin
                        if (scl_fall) begin
                            sda_oe <= 1'b0;
                            bitcnt <= '0;
                            st_q   <= ST_WR;
                        end
                    end
                    ST_RD: begin
                        if (scl_rise) bitcnt <= bitcnt + 1'b1;
                        if (byte_done) begin
                            sda_oe <= 1'b0;
                            ptr    <= ptr + 1'b1;
                            st_q   <= ST_RD_ACK;
                        end else if (scl_fall) begin
                            shreg  <= {shreg[6:0], 1'b0};
                            sda_oe <= ~shreg[6];
                        end
                    end
                    ST_RD_ACK: begin
                        if (scl_rise) mack_q <= ~sda_f;
                        if (scl_fall) begin
                            if (mack_q) begin
                                shreg  <= rd_data;
                                sda_oe <= ~rd_data[7];
                                bitcnt <= '0;
                                st_q   <= ST_RD;
                            end else begin
                                st_q   <= ST_IDLE;
                            end
                        end
                    end
                    default: st_q <= ST_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/osd_cfg_regfile.sv
// Module: configuration register file. It holds the writable overlay
// settings and returns read data for any pointer value. It assumes wr_en is
// a one-cycle strobe. Status addresses and unmapped addresses ignore writes;
// unmapped reads return zero.
module osd_cfg_regfile
    import i2c_cfg_pkg::*;
#(
    parameter int         N_CHAR   = NUM_CHAR,
    parameter int         N_CHAN   = NUM_CHAN,
    parameter logic [7:0] POS_RST  = 8'h00,
    parameter logic [5:0] CTRL_RST = 6'h00
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [7:0]            wr_addr,
    input  logic [7:0]            wr_data,
    input  logic [7:0]            rd_addr,
    output logic [7:0]            rd_data,
    input  logic [N_CHAN-1:0]     ch_nosig,
    input  logic [N_CHAN-1:0]     ch_unlock,
    input  logic [N_CHAN-1:0]     ch_active,
    output logic [7:0]            osd_pos,
    output logic [5:0]            osd_ctrl,
    output logic [N_CHAR*8-1:0]   osd_char,
    output logic [7:0]            osd_char_cnt
);
    localparam int PADW = 8 - N_CHAN;

    logic [7:0] char_q [N_CHAR];

    // Start position register.
    always_ff @(posedge clk) begin
        if (!rst_n)                          osd_pos <= POS_RST;
        else if (wr_en && wr_addr == REG_POS) osd_pos <= wr_data;
    end

    // Control register; only size and colour bits are kept.
    always_ff @(posedge clk) begin
        if (!rst_n)                           osd_ctrl <= CTRL_RST;
        else if (wr_en && wr_addr == REG_CTRL) osd_ctrl <= wr_data[5:0];
    end

    // Character count register.
    always_ff @(posedge clk) begin
        if (!rst_n)                               osd_char_cnt <= '0;
        else if (wr_en && wr_addr == REG_CHAR_CNT) osd_char_cnt <= wr_data;
    end

    for (genvar i = 0; i < N_CHAR; i++) begin : g_char
        // One character code register per slot.
        always_ff @(posedge clk) begin
            if (!rst_n) char_q[i] <= '0;
            else if (wr_en && wr_addr == REG_CHAR0 + 8'(i)) char_q[i] <= wr_data;
        end
        assign osd_char[8*i +: 8] = char_q[i];
    end

    // Read multiplexer over the whole map; live status, zero elsewhere.
    always_comb begin
        rd_data = 8'h00;
        for (int i = 0; i < N_CHAR; i++) begin
            if (rd_addr == REG_CHAR0 + 8'(i)) rd_data = char_q[i];
        end
        unique case (rd_addr)
            REG_CHAR_CNT: rd_data = osd_char_cnt;
            REG_POS:      rd_data = osd_pos;
            REG_CTRL:     rd_data = {2'b00, osd_ctrl};
            REG_NOSIG:    rd_data = {{PADW{1'b0}}, ch_nosig};
            REG_UNLOCK:   rd_data = {{PADW{1'b0}}, ch_unlock};
            REG_ACTIVE:   rd_data = {{PADW{1'b0}}, ch_active};
            default: ;
        endcase
    end

endmodule

// File: rtl/osd_cfg_i2c_slave.sv
// Module: top of the overlay configuration slave. It filters both bus lines,
// runs the protocol engine and holds the register file. It assumes that the
// SCL phases from the host are longer than the filter latency and that SDA
// is open drain outside this block (sda_oe = 1 pulls it low).
module osd_cfg_i2c_slave
    import i2c_cfg_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h30,
    parameter int         FILT_LEN = 3,
    parameter int         N_CHAR   = NUM_CHAR,
    parameter int         N_CHAN   = NUM_CHAN
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                scl_i,
    input  logic                sda_i,
    output logic                sda_oe,
    input  logic [N_CHAN-1:0]   ch_nosig,
    input  logic [N_CHAN-1:0]   ch_unlock,
    input  logic [N_CHAN-1:0]   ch_active,
    output logic [7:0]          osd_pos,
    output logic [5:0]          osd_ctrl,
    output logic [N_CHAR*8-1:0] osd_char,
    output logic [7:0]          osd_char_cnt
);
    logic [1:0] line_raw, line_filt;
    logic [7:0] ptr, rd_data, wr_addr, wr_data;
    logic       wr_en;

    assign line_raw = {sda_i, scl_i};

    for (genvar l = 0; l < 2; l++) begin : g_line
        i2c_glitch_filter #(.FILT_LEN(FILT_LEN)) u_filt (
            .clk    (clk),
            .rst_n  (rst_n),
            .line_i (line_raw[l]),
            .line_o (line_filt[l])
        );
    end

    i2c_bus_engine #(.DEV_ADDR(DEV_ADDR)) u_eng (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_f   (line_filt[0]),
        .sda_f   (line_filt[1]),
        .rd_data (rd_data),
        .ptr     (ptr),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .sda_oe  (sda_oe)
    );

    osd_cfg_regfile #(.N_CHAR(N_CHAR), .N_CHAN(N_CHAN)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .rd_addr      (ptr),
        .rd_data      (rd_data),
        .ch_nosig     (ch_nosig),
        .ch_unlock    (ch_unlock),
        .ch_active    (ch_active),
        .osd_pos      (osd_pos),
        .osd_ctrl     (osd_ctrl),
        .osd_char     (osd_char),
        .osd_char_cnt (osd_char_cnt)
    );

endmodule

// File: rtl/osd_cfg_i2c_chk.sv
// Module: property checker for the configuration slave, bound to the top.
// It relates the bus pins, the engine's write strobe and the register outputs.
module osd_cfg_i2c_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_i,
    input logic       sda_oe,
    input logic       wr_en,
    input logic [7:0] wr_addr,
    input logic [7:0] osd_pos,
    input logic [5:0] osd_ctrl,
    input logic [7:0] osd_char_cnt
);
    // R11
    sda_chg_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_i);

    // R3
    wr_strobe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !scl_i);

    // R4
    pos_wr_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(osd_pos) |-> ($past(wr_en) && $past(wr_addr) == 8'h31));

    // R5
    ctrl_wr_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(osd_ctrl) |-> ($past(wr_en) && $past(wr_addr) == 8'h32));

    // R7
    cnt_wr_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(osd_char_cnt) |-> ($past(wr_en) && $past(wr_addr) == 8'h07));

endmodule

bind osd_cfg_i2c_slave osd_cfg_i2c_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .scl_i        (scl_i),
    .sda_oe       (sda_oe),
    .wr_en        (wr_en),
    .wr_addr      (wr_addr),
    .osd_pos      (osd_pos),
    .osd_ctrl     (osd_ctrl),
    .osd_char_cnt (osd_char_cnt)
);

// File: tb/osd_cfg_i2c_slave_tb.sv
// Scoreboard bench: read tasks push expected bytes, the bus reader pushes
// the bytes it received, and a monitor process pairs and compares them.
module osd_cfg_i2c_slave_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic        sda_oe;
    logic [3:0]  ch_nosig  = 4'b1010;
    logic [3:0]  ch_unlock = 4'b0011;
    logic [3:0]  ch_active = 4'b1100;
    logic [7:0]  osd_pos, osd_char_cnt;
    logic [5:0]  osd_ctrl;
    logic [55:0] osd_char;
    logic        sda_bus;

    int n_chk  = 0;
    int n_fail = 0;

    logic [7:0] exp_val[$];
    string      exp_tag[$];
    logic [7:0] got_val[$];

    assign sda_bus = sda_m & ~sda_oe;

    always #2 clk = ~clk;

    osd_cfg_i2c_slave u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_i        (scl_m),
        .sda_i        (sda_bus),
        .sda_oe       (sda_oe),
        .ch_nosig     (ch_nosig),
        .ch_unlock    (ch_unlock),
        .ch_active    (ch_active),
        .osd_pos      (osd_pos),
        .osd_ctrl     (osd_ctrl),
        .osd_char     (osd_char),
        .osd_char_cnt (osd_char_cnt)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic expect_rd(input string tag, input logic [7:0] v);
        exp_tag.push_back(tag);
        exp_val.push_back(v);
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wbit(input logic b, input bit glitch);
        sda_m = b;
        wait_clk(10);
        scl_m = 1'b1;
        if (glitch) begin
            wait_clk(9);
            scl_m = 1'b0;
            wait_clk(2);
            scl_m = 1'b1;
            wait_clk(9);
        end else begin
            wait_clk(20);
        end
        scl_m = 1'b0;
        wait_clk(10);
    endtask

    task automatic rbit(output logic b);
        sda_m = 1'b1;
        wait_clk(10);
        scl_m = 1'b1;
        wait_clk(10);
        b = sda_bus;
        wait_clk(10);
        scl_m = 1'b0;
        wait_clk(10);
    endtask

    task automatic i2c_start;
        sda_m = 1'b1;
        wait_clk(10);
        scl_m = 1'b1;
        wait_clk(20);
        sda_m = 1'b0;
        wait_clk(20);
        scl_m = 1'b0;
        wait_clk(10);
    endtask

    task automatic i2c_stop;
        sda_m = 1'b0;
        wait_clk(10);
        scl_m = 1'b1;
        wait_clk(20);
        sda_m = 1'b1;
        wait_clk(20);
    endtask

    task automatic wbyte(input logic [7:0] v, input bit glitch, output bit ack);
        logic b;
        for (int i = 7; i >= 0; i--) wbit(v[i], glitch && i == 4);
        rbit(b);
        ack = !b;
    endtask

    task automatic rbyte(input bit host_ack, input bit flip);
        logic [7:0] v;
        logic b;
        for (int i = 0; i < 8; i++) begin
            rbit(b);
            v = {v[6:0], b};
            if (flip && i == 2) ch_nosig = ~ch_nosig;
        end
        wbit(!host_ack, 1'b0);
        got_val.push_back(v);
    endtask

    // Write transfer: pointer byte then data bytes, every ack checked.
    task automatic wr_regs(input string tag, input logic [7:0] p, input logic [7:0] d[$]);
        bit a;
        i2c_start;
        wbyte(8'h60, 1'b0, a);
        chk({tag, " addr ack"}, 64'(a), 64'd1);
        wbyte(p, 1'b0, a);
        chk({tag, " ptr ack"}, 64'(a), 64'd1);
        foreach (d[k]) begin
            wbyte(d[k], 1'b0, a);
            chk({tag, " data ack"}, 64'(a), 64'd1);
        end
        i2c_stop;
    endtask

    // Read transfer of n bytes from pointer p via repeated START.
    task automatic rd_regs(input string tag, input logic [7:0] p, input int n, input bit flip);
        bit a;
        i2c_start;
        wbyte(8'h60, 1'b0, a);
        wbyte(p, 1'b0, a);
        i2c_start;
        wbyte(8'h61, 1'b0, a);
        chk({tag, " read addr ack (R11 restart)"}, 64'(a), 64'd1);
        for (int k = 0; k < n; k++) rbyte(k < n - 1, flip && k == 0);
        i2c_stop;
        chk({tag, " R9 released after NACK/STOP"}, 64'(sda_oe), 64'd0);
    endtask

    // Monitor: compare received bytes with the expected queue.
    initial begin
        forever begin
            @(negedge clk);
            while (got_val.size() > 0) begin
                logic [7:0] g;
                g = got_val.pop_front();
                n_chk++;
                if (exp_val.size() == 0) begin
                    n_fail++;
                    $display("FAIL scoreboard: actual %0h expected none", g);
                end else begin
                    string t;
                    logic [7:0] e;
                    t = exp_tag.pop_front();
                    e = exp_val.pop_front();
                    if (g !== e) begin
                        n_fail++;
                        $display("FAIL %s: actual %0h expected %0h", t, g, e);
                    end
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] q[$];
        bit a;
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(2);
        // R1 reset state
        chk("R1 pos", 64'(osd_pos), 64'd0);
        chk("R1 ctrl", 64'(osd_ctrl), 64'd0);
        chk("R1 chars", 64'(osd_char), 64'd0);
        chk("R1 count", 64'(osd_char_cnt), 64'd0);
        chk("R1 sda_oe", 64'(sda_oe), 64'd0);

        // R3 R4 position write
        q = '{8'hA5};
        wr_regs("R3", 8'h31, q);
        chk("R4 pos", 64'(osd_pos), 64'hA5);

        // R5 control keeps six bits
        q = '{8'hFF};
        wr_regs("R5", 8'h32, q);
        chk("R5 ctrl", 64'(osd_ctrl), 64'h3F);

        // R3 R4 burst over characters and count
        q = '{8'h41, 8'h42, 8'h43, 8'h44, 8'h45, 8'h46, 8'h47, 8'h48};
        wr_regs("R3 burst", 8'h00, q);
        chk("R4 chars", 64'(osd_char), 64'h47_46_45_44_43_42_41);
        chk("R4 count", 64'(osd_char_cnt), 64'h48);

        // R9 burst read, R5 readback of control
        for (int k = 0; k < 8; k++) expect_rd("R9 burst read", 8'h41 + 8'(k));
        rd_regs("R9", 8'h00, 8, 1'b0);
        expect_rd("R5 ctrl readback", 8'h3F);
        rd_regs("R5", 8'h32, 1, 1'b0);

        // R2 wrong address is NACKed and ignored
        i2c_start;
        wbyte(8'h52, 1'b0, a);
        chk("R2 nack", 64'(a), 64'd0);
        wbyte(8'h31, 1'b0, a);
        wbyte(8'h00, 1'b0, a);
        i2c_stop;
        chk("R2 pos unchanged", 64'(osd_pos), 64'hA5);

        // R7 writes to status and unmapped addresses
        q = '{8'hFF, 8'hFF, 8'hFF};
        wr_regs("R7 status", 8'h11, q);
        q = '{8'h77};
        wr_regs("R7 unmapped", 8'h40, q);
        chk("R7 pos", 64'(osd_pos), 64'hA5);
        chk("R7 ctrl", 64'(osd_ctrl), 64'h3F);
        chk("R7 chars", 64'(osd_char), 64'h47_46_45_44_43_42_41);
        chk("R7 count", 64'(osd_char_cnt), 64'h48);

        // R6 status reads, R8 unmapped read
        expect_rd("R6 nosig", 8'h0A);
        expect_rd("R6 unlock", 8'h03);
        expect_rd("R6 active", 8'h0C);
        rd_regs("R6", 8'h11, 3, 1'b0);
        expect_rd("R8 unmapped", 8'h00);
        rd_regs("R8", 8'h40, 1, 1'b0);

        // R10 status sampled at byte load
        expect_rd("R10 held byte", 8'h0A);
        rd_regs("R10", 8'h11, 1, 1'b1);
        expect_rd("R10 new value", 8'h05);
        rd_regs("R10 next", 8'h11, 1, 1'b0);

        // R12 short SCL glitch during a data bit and short SDA glitch at idle
        sda_m = 1'b0;
        wait_clk(2);
        sda_m = 1'b1;
        wait_clk(10);
        i2c_start;
        wbyte(8'h60, 1'b0, a);
        wbyte(8'h07, 1'b0, a);
        wbyte(8'h3C, 1'b1, a);
        chk("R12 ack", 64'(a), 64'd1);
        i2c_stop;
        chk("R12 count", 64'(osd_char_cnt), 64'h3C);

        wait_clk(5);
        chk("R9 scoreboard drained", 64'(exp_val.size()), 64'd0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule